// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

The block collects the interrupt sources that belong to each core of a four-core cluster and steers each one onto that core's IRQ or FIQ line. There are four timer lines per core, four mailbox "not empty" flags per core, one performance-monitor line per core, and one external line that all cores share. A small 32-bit register bus holds the enables and routing selections. Each core can read a pending register that shows which of its sources are asserted and routed to it.

The register bus has a write strobe, a byte address and write data. Read data is combinational from the address. Timer and mailbox enables live in one register per core. The performance-monitor enables sit in a single register that is changed through two addresses, one that sets bits and one that clears them. The shared line carries two encoded core numbers, one for IRQ delivery and one for FIQ delivery. A control word and a prescaler word are held and read back, and have no effect on routing. The mailbox storage lives in a neighbouring block. Only its per-mailbox non-empty flags come in here.

Top module: `core_irq_router`

## Requirements
- R1: After reset every writable register reads 0, and with all sources idle every `irq_o` and `fiq_o` bit is 0.
- R2: The control word (0x00) and the prescaler word (0x08) store all 32 written bits and read them back, for example 0x80000000.
- R3: The timer enable register of core c is at 0x40+4c. Bit n sends timer n of that core to its IRQ, and bit n+4 sends it to its FIQ. Pending bit n of core c is set when timer n is high and either of its two enables is set.
- R4: The mailbox enable register of core c is at 0x50+4c. Bit n sends mailbox flag n to IRQ, and bit n+4 sends it to FIQ. Pending bit 4+n follows the same rule as the timers.
- R5: The shared-line route register at 0x0C holds the IRQ target core in bits [1:0] and the FIQ target core in bits [3:2]. Only those cores see the shared line: on pending bit 8, and on IRQ or FIQ respectively. A new route takes effect on the next cycle, even while the line is held high.
- R6: The monitor enable register has bit c for core c's IRQ and bit c+4 for core c's FIQ. A write to 0x10 ORs in the written ones. A write to 0x14 removes them. Zero bits, written-data bits above bit 7, and writes to other addresses leave the register unchanged. It reads back at both addresses.
- R7: Pending bit 9 of core c is set when that core's monitor line is high and either of its monitor enables is set. The line reaches IRQ or FIQ according to the matching enable.
- R8: The pending register of core c is at 0x60+4c and is read-only. Writing to it changes no register and no output.
- R9: Pending bits 10 and 11 and all bits above them read 0. Unmapped addresses read 0.
- R10: A core's `irq_o` is the OR of its IRQ-enabled asserted sources, and `fiq_o` is the OR of its FIQ-enabled ones. Neither is ever high while that core's pending register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| timer_i | input | 16 | Timer lines, core c timer n at bit 4c+n |
| mbox_nz_i | input | 16 | Mailbox non-empty flags, core c mailbox n at bit 4c+n |
| pmu_i | input | 4 | Performance-monitor line per core |
| shared_i | input | 1 | Shared external interrupt line |
| irq_o | output | 4 | IRQ per core |
| fiq_o | output | 4 | FIQ per core |

## Verification
Every one of the 256 enable values of each core's timer and mailbox registers is paired with all 16 line patterns of that core. Meanwhile every other core's lines are held high with zero enables, so any cross-core leak shows up as a wrong pending value. All 16 shared-route values are stepped with the shared line held high and then low. This separates the IRQ core from the FIQ core and confirms the route follows each rewrite. The monitor enables go through a set/clear sequence that exposes OR-versus-overwrite and AND-NOT-versus-clear mistakes, followed by a sweep of all enable values against all line patterns. Writes to the pending addresses and reads of unmapped addresses confirm that nothing changes and that zero is returned.

// File: rtl/core_irq_router_pkg.sv
package core_irq_router_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PEND_W = 12;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PSC  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SHR  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_PSET = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_PCLR = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_TCFG = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_MCFG = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_PEND = 8'h60;
endpackage

// File: rtl/cir_regs.sv
module cir_regs
  import core_irq_router_pkg::*;
#(
  parameter int unsigned NCORE = 4,
  parameter int unsigned NTMR  = 4,
  parameter int unsigned NMBX  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [NCORE*PEND_W-1:0]   pend_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [NCORE*2*NTMR-1:0]   tcfg_o,
  output logic [NCORE*2*NMBX-1:0]   mcfg_o,
  output logic [SEL_W-1:0]          shr_irq_sel_o,
  output logic [SEL_W-1:0]          shr_fiq_sel_o,
  output logic [2*NCORE-1:0]        pmu_en_o
);
  localparam int unsigned TW = 2 * NTMR;
  localparam int unsigned MW = 2 * NMBX;
  localparam int unsigned PW = 2 * NCORE;

  logic [DATA_W-1:0]  ctrl_q, psc_q;
  logic [2*SEL_W-1:0] shr_q;
  logic [PW-1:0]      pmu_q;
  logic [TW-1:0]      tcfg_q [NCORE];
  logic [MW-1:0]      mcfg_q [NCORE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      shr_q  <= '0;
      pmu_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFF_CTRL: ctrl_q <= wdata_i;
        OFF_PSC:  psc_q  <= wdata_i;
        OFF_SHR:  shr_q  <= wdata_i[2*SEL_W-1:0];
        OFF_PSET: pmu_q  <= pmu_q | wdata_i[PW-1:0];
        OFF_PCLR: pmu_q  <= pmu_q & ~wdata_i[PW-1:0];
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    localparam logic [ADDR_W-1:0] T_ADDR = OFF_TCFG + ADDR_W'(4 * c);
    localparam logic [ADDR_W-1:0] M_ADDR = OFF_MCFG + ADDR_W'(4 * c);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tcfg_q[c] <= '0;
        mcfg_q[c] <= '0;
      end else if (we_i) begin
        if (addr_i == T_ADDR) tcfg_q[c] <= wdata_i[TW-1:0];
        if (addr_i == M_ADDR) mcfg_q[c] <= wdata_i[MW-1:0];
      end
    end

    assign tcfg_o[c*TW +: TW] = tcfg_q[c];
    assign mcfg_o[c*MW +: MW] = mcfg_q[c];
  end

  assign shr_irq_sel_o = shr_q[SEL_W-1:0];
  assign shr_fiq_sel_o = shr_q[2*SEL_W-1:SEL_W];
  assign pmu_en_o      = pmu_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL:           rdata_o = ctrl_q;
      OFF_PSC:            rdata_o = psc_q;
      OFF_SHR:            rdata_o = DATA_W'(shr_q);
      OFF_PSET, OFF_PCLR: rdata_o = DATA_W'(pmu_q);
      default: begin
        for (int c = 0; c < NCORE; c++) begin
          if (addr_i == OFF_TCFG + ADDR_W'(4 * c)) rdata_o = DATA_W'(tcfg_q[c]);
          if (addr_i == OFF_MCFG + ADDR_W'(4 * c)) rdata_o = DATA_W'(mcfg_q[c]);
          if (addr_i == OFF_PEND + ADDR_W'(4 * c)) rdata_o = DATA_W'(pend_i[c*PEND_W +: PEND_W]);
        end
      end
    endcase
  end
endmodule

// File: rtl/cir_core_slice.sv
module cir_core_slice
  import core_irq_router_pkg::*;
#(
  parameter int unsigned NTMR = 4,
  parameter int unsigned NMBX = 4
) (
  input  logic [2*NTMR-1:0] tcfg_i,
  input  logic [2*NMBX-1:0] mcfg_i,
  input  logic [NTMR-1:0]   timer_i,
  input  logic [NMBX-1:0]   mbox_i,
  input  logic              pmu_i,
  input  logic              pmu_irq_en_i,
  input  logic              pmu_fiq_en_i,
  input  logic              shared_i,
  input  logic              shr_irq_hit_i,
  input  logic              shr_fiq_hit_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned SHR_BIT = NTMR + NMBX;
  localparam int unsigned PMU_BIT = SHR_BIT + 1;

  logic [NTMR-1:0] t_irq, t_fiq;
  logic [NMBX-1:0] m_irq, m_fiq;
  logic            s_irq, s_fiq, p_irq, p_fiq;

  assign t_irq = timer_i & tcfg_i[NTMR-1:0];
  assign t_fiq = timer_i & tcfg_i[2*NTMR-1:NTMR];
  assign m_irq = mbox_i  & mcfg_i[NMBX-1:0];
  assign m_fiq = mbox_i  & mcfg_i[2*NMBX-1:NMBX];
  assign s_irq = shared_i & shr_irq_hit_i;
  assign s_fiq = shared_i & shr_fiq_hit_i;
  assign p_irq = pmu_i & pmu_irq_en_i;
  assign p_fiq = pmu_i & pmu_fiq_en_i;

  always_comb begin
    pend_o = '0;
    pend_o[NTMR-1:0]       = t_irq | t_fiq;
    pend_o[SHR_BIT-1:NTMR] = m_irq | m_fiq;
    pend_o[SHR_BIT]        = s_irq | s_fiq;
    pend_o[PMU_BIT]        = p_irq | p_fiq;
  end

  assign irq_o = (|t_irq) | (|m_irq) | s_irq | p_irq;
  assign fiq_o = (|t_fiq) | (|m_fiq) | s_fiq | p_fiq;
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import core_irq_router_pkg::*;
#(
  parameter int unsigned NCORE = 4,
  parameter int unsigned NTMR  = 4,
  parameter int unsigned NMBX  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  input  logic [NCORE*NTMR-1:0]   timer_i,
  input  logic [NCORE*NMBX-1:0]   mbox_nz_i,
  input  logic [NCORE-1:0]        pmu_i,
  input  logic                    shared_i,
  output logic [NCORE-1:0]        irq_o,
  output logic [NCORE-1:0]        fiq_o
);
  localparam int unsigned SEL_W = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam int unsigned TW    = 2 * NTMR;
  localparam int unsigned MW    = 2 * NMBX;

  logic [NCORE*PEND_W-1:0] pend;
  logic [NCORE*TW-1:0]     tcfg;
  logic [NCORE*MW-1:0]     mcfg;
  logic [SEL_W-1:0]        shr_irq_sel, shr_fiq_sel;
  logic [2*NCORE-1:0]      pmu_en;

  cir_regs #(
    .NCORE(NCORE), .NTMR(NTMR), .NMBX(NMBX), .SEL_W(SEL_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .pend_i       (pend),
    .rdata_o      (reg_rdata_o),
    .tcfg_o       (tcfg),
    .mcfg_o       (mcfg),
    .shr_irq_sel_o(shr_irq_sel),
    .shr_fiq_sel_o(shr_fiq_sel),
    .pmu_en_o     (pmu_en)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_slice
    cir_core_slice #(.NTMR(NTMR), .NMBX(NMBX)) u_slice (
      .tcfg_i       (tcfg[c*TW +: TW]),
      .mcfg_i       (mcfg[c*MW +: MW]),
      .timer_i      (timer_i[c*NTMR +: NTMR]),
      .mbox_i       (mbox_nz_i[c*NMBX +: NMBX]),
      .pmu_i        (pmu_i[c]),
      .pmu_irq_en_i (pmu_en[c]),
      .pmu_fiq_en_i (pmu_en[c+NCORE]),
      .shared_i     (shared_i),
      .shr_irq_hit_i(shr_irq_sel == SEL_W'(c)),
      .shr_fiq_hit_i(shr_fiq_sel == SEL_W'(c)),
      .pend_o       (pend[c*PEND_W +: PEND_W]),
      .irq_o        (irq_o[c]),
      .fiq_o        (fiq_o[c])
    );
  end
endmodule

// File: rtl/core_irq_router_chk.sv
module core_irq_router_chk
  import core_irq_router_pkg::*;
#(
  parameter int unsigned NCORE = 4,
  parameter int unsigned USED  = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [2*NCORE-1:0]      wdata_i,
  input logic                    shared_i,
  input logic [NCORE-1:0]        irq_i,
  input logic [NCORE-1:0]        fiq_i,
  input logic [NCORE*PEND_W-1:0] pend_i,
  input logic [2*NCORE-1:0]      pmu_en_i
);
  localparam int unsigned SHR_BIT = USED - 2;

  logic [NCORE-1:0] shr_seen;
  always_comb
    for (int c = 0; c < NCORE; c++) shr_seen[c] = pend_i[c*PEND_W + SHR_BIT];

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assert_irq_needs_pend_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[c] |-> (pend_i[c*PEND_W +: PEND_W] != '0));
    assert_fiq_needs_pend_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fiq_i[c] |-> (pend_i[c*PEND_W +: PEND_W] != '0));
    assert_spare_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_i[c*PEND_W + USED +: PEND_W - USED] == '0);
  end

  assert_shared_two_cores_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(shr_seen) <= 2);
  assert_shared_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shared_i |-> (shr_seen == '0));
  assert_pmu_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_PSET) |=> ((pmu_en_i & $past(wdata_i)) == $past(wdata_i)));
  assert_pmu_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_PCLR) |=> ((pmu_en_i & $past(wdata_i)) == '0));
  assert_pmu_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == OFF_PSET || addr_i == OFF_PCLR)) |=> $stable(pmu_en_i));
endmodule

bind core_irq_router core_irq_router_chk #(
  .NCORE(NCORE), .USED(NTMR + NMBX + 2)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (reg_we_i),
  .addr_i  (reg_addr_i),
  .wdata_i (reg_wdata_i[2*NCORE-1:0]),
  .shared_i(shared_i),
  .irq_i   (irq_o),
  .fiq_i   (fiq_o),
  .pend_i  (pend),
  .pmu_en_i(pmu_en)
);

// File: tb/tb_core_irq_router.sv
module tb_core_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] timer = '0;
  logic [15:0] mbox = '0;
  logic [3:0]  pmu = '0;
  logic        shared = 1'b0;
  logic [3:0]  irq, fiq;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0]  tcfg_m [4];
  logic [7:0]  mcfg_m [4];
  logic [3:0]  shr_m;
  logic [7:0]  pmu_m;

  always #5 clk = ~clk;

  core_irq_router dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .timer_i(timer),
    .mbox_nz_i(mbox), .pmu_i(pmu), .shared_i(shared), .irq_o(irq), .fiq_o(fiq)
  );

  function automatic logic [11:0] exp_pend(int c);
    logic [11:0] p = '0;
    for (int n = 0; n < 4; n++) begin
      p[n]   = timer[c*4+n] & (tcfg_m[c][n] | tcfg_m[c][n+4]);
      p[4+n] = mbox[c*4+n]  & (mcfg_m[c][n] | mcfg_m[c][n+4]);
    end
    p[8] = shared & ((shr_m[1:0] == 2'(c)) | (shr_m[3:2] == 2'(c)));
    p[9] = pmu[c] & (pmu_m[c] | pmu_m[c+4]);
    return p;
  endfunction

  function automatic logic exp_line(int c, bit fq);
    logic r = 1'b0;
    int o = fq ? 4 : 0;
    for (int n = 0; n < 4; n++) begin
      r |= timer[c*4+n] & tcfg_m[c][n+o];
      r |= mbox[c*4+n]  & mcfg_m[c][n+o];
    end
    r |= shared & (fq ? (shr_m[3:2] == 2'(c)) : (shr_m[1:0] == 2'(c)));
    r |= pmu[c] & pmu_m[c+o];
    return r;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    we = 1'b0; addr = a;
    #1;
    d = rdata;
  endtask

  task automatic check_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    bus_read(a, d);
    n_tests++;
    if (d !== e) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, d, e);
    end
  endtask

  // pending, irq and fiq of every core against the model (R10 always applies)
  task automatic check_cores(input string tag);
    logic [31:0] d;
    for (int c = 0; c < 4; c++) begin
      bus_read(8'h60 + 8'(4*c), d);
      n_tests++;
      if (d !== {20'h0, exp_pend(c)} || irq[c] !== exp_line(c, 0) || fiq[c] !== exp_line(c, 1)) begin
        n_fail++;
        $display("FAIL %s/R10 core%0d actual pend=%h irq=%b fiq=%b expected pend=%h irq=%b fiq=%b",
                 tag, c, d, irq[c], fiq[c], exp_pend(c), exp_line(c, 0), exp_line(c, 1));
      end
    end
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin tcfg_m[c] = '0; mcfg_m[c] = '0; end
    shr_m = '0; pmu_m = '0;
    #22 rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    foreach (tcfg_m[c]) begin
      check_reg(8'h40 + 8'(4*c), 32'h0, "R1");
      check_reg(8'h50 + 8'(4*c), 32'h0, "R1");
    end
    check_reg(8'h00, 32'h0, "R1");
    check_reg(8'h08, 32'h0, "R1");
    check_reg(8'h0C, 32'h0, "R1");
    check_reg(8'h10, 32'h0, "R1");
    n_tests++;
    if (irq !== 4'h0 || fiq !== 4'h0) begin
      n_fail++;
      $display("FAIL R1 irq=%b fiq=%b expected 0000/0000", irq, fiq);
    end

    // R2: control and prescaler hold all bits
    bus_write(8'h00, 32'hA5C3_5A3C);
    bus_write(8'h08, 32'h8000_0000);
    check_reg(8'h00, 32'hA5C3_5A3C, "R2");
    check_reg(8'h08, 32'h8000_0000, "R2");
    check_cores("R2");

    // R3: timer enables, other cores' lines high with zero enables
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 256; v++) begin
        bus_write(8'h40 + 8'(4*c), 32'(v));
        tcfg_m[c] = 8'(v);
        check_reg(8'h40 + 8'(4*c), 32'(v), "R3");
        for (int t = 0; t < 16; t++) begin
          timer = 16'hFFFF;
          timer[c*4 +: 4] = 4'(t);
          check_cores("R3");
        end
      end
      bus_write(8'h40 + 8'(4*c), 32'h0);
      tcfg_m[c] = '0;
    end
    timer = '0;

    // R4: mailbox enables
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 256; v++) begin
        bus_write(8'h50 + 8'(4*c), 32'(v));
        mcfg_m[c] = 8'(v);
        check_reg(8'h50 + 8'(4*c), 32'(v), "R4");
        for (int t = 0; t < 16; t++) begin
          mbox = 16'hFFFF;
          mbox[c*4 +: 4] = 4'(t);
          check_cores("R4");
        end
      end
      bus_write(8'h50 + 8'(4*c), 32'h0);
      mcfg_m[c] = '0;
    end
    mbox = '0;

    // R5: shared route moved while line held high, then with line low
    shared = 1'b1;
    for (int r = 0; r < 16; r++) begin
      bus_write(8'h0C, 32'(r));
      shr_m = 4'(r);
      check_reg(8'h0C, 32'(r), "R5");
      check_cores("R5");
    end
    shared = 1'b0;
    for (int r = 0; r < 16; r++) begin
      bus_write(8'h0C, 32'(r));
      shr_m = 4'(r);
      check_cores("R5");
    end

    // R6: set/clear sequence
    bus_write(8'h10, 32'h0F);       pmu_m |= 8'h0F;
    check_reg(8'h10, 32'h0F, "R6");
    bus_write(8'h10, 32'hF0);       pmu_m |= 8'hF0;
    check_reg(8'h14, 32'hFF, "R6");
    bus_write(8'h14, 32'h33);       pmu_m &= ~8'h33;
    check_reg(8'h10, 32'hCC, "R6");
    bus_write(8'h14, 32'h0);
    check_reg(8'h10, 32'hCC, "R6");
    bus_write(8'h10, 32'hFFFF_FF00);
    check_reg(8'h14, 32'hCC, "R6");
    bus_write(8'h00, 32'hFF);
    check_reg(8'h10, 32'hCC, "R6");
    bus_write(8'h14, 32'hFF);       pmu_m = '0;
    check_reg(8'h10, 32'h00, "R6");

    // R7: monitor routing sweep
    for (int v = 0; v < 256; v++) begin
      bus_write(8'h10, 32'(v));
      pmu_m = 8'(v);
      for (int t = 0; t < 16; t++) begin
        pmu = 4'(t);
        check_cores("R7");
      end
      bus_write(8'h14, 32'(v));
      pmu_m = '0;
      check_reg(8'h10, 32'h0, "R7");
    end

    // R8: pending registers are read-only
    bus_write(8'h40, 32'h11); tcfg_m[0] = 8'h11;
    bus_write(8'h54, 32'h82); mcfg_m[1] = 8'h82;
    bus_write(8'h10, 32'h48); pmu_m = 8'h48;
    bus_write(8'h0C, 32'h9);  shr_m = 4'h9;
    timer = 16'h0F0F; mbox = 16'h00F0; pmu = 4'hF; shared = 1'b1;
    for (int c = 0; c < 4; c++) bus_write(8'h60 + 8'(4*c), 32'hFFFF_FFFF);
    check_cores("R8");
    check_reg(8'h40, 32'h11, "R8");
    check_reg(8'h54, 32'h82, "R8");
    check_reg(8'h10, 32'h48, "R8");
    check_reg(8'h0C, 32'h9, "R8");

    // R9: unmapped addresses and spare pending bits
    check_reg(8'h04, 32'h0, "R9");
    check_reg(8'h18, 32'h0, "R9");
    check_reg(8'h70, 32'h0, "R9");
    check_reg(8'hFC, 32'h0, "R9");
    timer = '1; mbox = '1; pmu = '1;
    check_cores("R9");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule